// File: doc/BRIEF.md
# Sampled Digital Input Noise Filter

This block cleans a bank of external input lines (five by default) before they reach downstream edge-detection logic. Each line first crosses into the system clock domain through a two-flop synchronizer. When filtering is on, the synchronized level is sampled at a programmable rate. The filtered output takes a new level only after three consecutive samples agree on it. A pulse that covers no more than two sampling periods can therefore never reach the output.

Software configures the block through one 8-bit register. An enable bit chooses between filtered mode and plain synchronized pass-through. A 3-bit code chooses the sampling rate: the system clock itself, or the system clock divided by 4, 8, 16, 32 or 64. The rate is produced by an internal prescaler that emits a one-cycle sample strobe, not a derived clock. Changing the rate clears the prescaler and the sample history. A `settled` output then stays low until three fresh sampling periods have passed, and during that time the filtered outputs hold their previous level.

Top module: `glitch_filter_bank`

## Requirements
- R1: During reset and just after it, the register reads 00h, `pins_out` is 0 and `settled` is 0. `settled` rises after the third clock edge following reset release, because code 000 gives a sampling period of 1 cycle.
- R2: In register layout, bit 7 is the enable bit (1 = filter, 0 = bypass) and bits 2:0 are the rate code. Bits 6:3 always read back as 0, whatever was written. A write takes effect at the clock edge where `reg_we` is high, and `reg_rdata` shows the new value from then on.
- R3: A write with rate code 110 or 111 leaves the previous rate code in effect and starts no re-initialization. The enable bit of that same write is still applied.
- R4: The sampling period is 1 cycle for code 000, 4 cycles for 001, 8 for 010, 16 for 011, 32 for 100 and 64 for 101.
- R5: A write that changes the rate code drives `settled` low from that write's clock edge. `settled` returns high exactly 3 sampling periods (3×D cycles) after that edge. A write that repeats the current code leaves `settled` high.
- R6: With the enable bit 0, each `pins_out` bit equals the matching `pins_in` bit delayed by exactly two clock edges.
- R7: With the enable bit 1, a filtered output changes only after three consecutive samples of the synchronized input agree on the new level. A level held steady for at least 3×D+4 cycles always appears at the output, and it never appears within 2×D+1 edges of the input change.
- R8: With filtering on, a pulse of either polarity that lasts 2×D cycles or less never changes the output.
- R9: While `settled` is low with filtering on, `pins_out` holds its value.
- R10: Channels are filtered independently. A glitch on one line does not affect another line's output or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| pins_in | input | NUM_CH | Raw external input lines |
| pins_out | output | NUM_CH | Synchronized, optionally filtered lines |
| settled | output | 1 | High once the filter has collected three samples since the last rate change |

## Verification
The checker watches four rules on every cycle:
- the reserved register bits read as zero and the rate code stays legal;
- a rate change is followed by `settled` going low;
- outputs are frozen while the filter re-initializes;
- in bypass the output equals the input two edges earlier, and in filtered mode an output can only move two cycles after a sample strobe.

Some behaviour is shown only by the bench's directed scenarios, which hold the input steady or pulse it at several phases against the prescaler and at several rates:
- the exact settling delay for each divisor;
- that prohibited codes are rejected;
- that short pulses of both polarities are suppressed;
- that channels are independent.

// File: rtl/nf_pkg.sv
package nf_pkg;

  localparam int SEL_W = 3;
  localparam int DIV_W = 7;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } nf_cfg_t;

  // Codes 0..5 are usable; 6 and 7 are rejected on write.
  function automatic logic code_is_legal(input logic [SEL_W-1:0] code);
    return code <= 3'd5;
  endfunction

  // Sampling period in system clock cycles for a legal code.
  function automatic logic [DIV_W-1:0] code_to_div(input logic [SEL_W-1:0] code);
    if (code == 3'd0) return 7'd1;
    return 7'd1 << (code + 3'd1);
  endfunction

endpackage

// File: rtl/nf_ctrl_reg.sv
module nf_ctrl_reg
  import nf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [7:0]    wdata,
  output nf_cfg_t       cfg,
  output logic [7:0]    rdata,
  output logic          restart
);

  logic [SEL_W-1:0] new_code;
  assign new_code = wdata[SEL_W-1:0];

  // A legal, different code re-initializes the sampling path.
  assign restart = we && code_is_legal(new_code) && (new_code != cfg.sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (we) begin
      cfg.en <= wdata[7];
      if (code_is_legal(new_code)) cfg.sel <= new_code;
    end
  end

  assign rdata = {cfg.en, 4'b0000, cfg.sel};

endmodule

// File: rtl/nf_prescaler.sv
module nf_prescaler #(
  parameter int CNT_W = 6,
  localparam int DIV_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q;
  logic [DIV_W-1:0] last;

  assign last = div - DIV_W'(1);
  assign tick = ({1'b0, cnt_q} == last) && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt_q <= '0;
    else if (tick)         cnt_q <= '0;
    else                   cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/nf_settle.sv
module nf_settle #(
  parameter int SAMPLES = 3,
  localparam int FW = $clog2(SAMPLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  output logic settled
);

  logic [FW-1:0] fill_q;

  assign settled = (fill_q == FW'(SAMPLES));

  always_ff @(posedge clk) begin
    if (!rst_n || restart)    fill_q <= '0;
    else if (tick && !settled) fill_q <= fill_q + FW'(1);
  end

endmodule

// File: rtl/nf_channel.sv
module nf_channel #(
  parameter int SYNC_STAGES = 2,
  parameter int SAMPLES     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic en,
  input  logic tick,
  input  logic tick_d,
  input  logic settled,
  input  logic restart,
  output logic sync_o,
  output logic out
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SAMPLES-1:0]     hist_q;
  logic                   filt_q;
  logic                   agree;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
  end
  assign sync_o = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n || restart) hist_q <= '0;
    else if (tick)         hist_q <= {hist_q[SAMPLES-2:0], sync_o};
  end

  assign agree = (&hist_q) || (~|hist_q);

  // In bypass the filter state tracks the synchronizer so enabling is seamless.
  always_ff @(posedge clk) begin
    if (!rst_n)                          filt_q <= 1'b0;
    else if (!en)                        filt_q <= sync_o;
    else if (tick_d && settled && agree) filt_q <= hist_q[0];
  end

  assign out = en ? filt_q : sync_o;

endmodule

// File: rtl/glitch_filter_bank.sv
module glitch_filter_bank #(
  parameter int NUM_CH      = 5,
  parameter int SYNC_STAGES = 2,
  parameter int SAMPLES     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [NUM_CH-1:0] pins_in,
  output logic [NUM_CH-1:0] pins_out,
  output logic              settled
);
  import nf_pkg::*;

  localparam int CNT_W = DIV_W - 1;

  nf_cfg_t           cfg;
  logic              cfg_en;
  logic              restart_req;
  logic              sample_tick;
  logic              tick_d;
  logic [DIV_W-1:0]  div;
  logic [NUM_CH-1:0] sync_lvl;

  nf_ctrl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .wdata   (reg_wdata),
    .cfg     (cfg),
    .rdata   (reg_rdata),
    .restart (restart_req)
  );

  assign cfg_en = cfg.en;
  assign div    = code_to_div(cfg.sel);

  nf_prescaler #(.CNT_W(CNT_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart_req),
    .div     (div),
    .tick    (sample_tick)
  );

  nf_settle #(.SAMPLES(SAMPLES)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart_req),
    .tick    (sample_tick),
    .settled (settled)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) tick_d <= 1'b0;
    else        tick_d <= sample_tick;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    nf_channel #(.SYNC_STAGES(SYNC_STAGES), .SAMPLES(SAMPLES)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin     (pins_in[c]),
      .en      (cfg_en),
      .tick    (sample_tick),
      .tick_d  (tick_d),
      .settled (settled),
      .restart (restart_req),
      .sync_o  (sync_lvl[c]),
      .out     (pins_out[c])
    );
  end

endmodule

// File: rtl/nf_checker.sv
module nf_checker #(
  parameter int NUM_CH = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic              settled,
  input logic              restart_req,
  input logic              sample_tick,
  input logic [7:0]        reg_rdata,
  input logic [NUM_CH-1:0] pins_in,
  input logic [NUM_CH-1:0] pins_out
);

  // Counts clean edges since reset so two-deep history is trustworthy.
  logic [1:0] age_q;
  logic       warm;
  always_ff @(posedge clk) begin
    if (!rst_n)             age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end
  assign warm = (age_q == 2'd2);

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[6:3] == 4'b0000);

  p_code_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[2:0] <= 3'd5);

  p_reinit_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |=> !settled);

  p_hold_reinit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && !settled) |=> (!cfg_en || pins_out == $past(pins_out)));

  p_bypass_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !cfg_en) |-> pins_out == $past(pins_in, 2));

  p_move_after_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && cfg_en && $past(cfg_en) && pins_out != $past(pins_out))
      |-> $past(sample_tick, 2));

endmodule

bind glitch_filter_bank nf_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_en      (cfg_en),
  .settled     (settled),
  .restart_req (restart_req),
  .sample_tick (sample_tick),
  .reg_rdata   (reg_rdata),
  .pins_in     (pins_in),
  .pins_out    (pins_out)
);

// File: tb/glitch_filter_bank_test.sv
module glitch_filter_bank_test;

  localparam int NCH = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_we = 1'b0;
  logic [7:0]     reg_wdata = '0;
  logic [7:0]     reg_rdata;
  logic [NCH-1:0] pins_in = '0;
  logic [NCH-1:0] pins_out;
  logic           settled;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  glitch_filter_bank #(.NUM_CH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pins_in(pins_in), .pins_out(pins_out),
    .settled(settled)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Sampling period per code, restated from the requirement table.
  function automatic int period_of(input int code);
    case (code)
      0: return 1;
      1: return 4;
      2: return 8;
      3: return 16;
      4: return 32;
      5: return 64;
      default: return 0;
    endcase
  endfunction

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_settled();
    while (!settled) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(reg_rdata == 8'h00, "R1", "rdata in reset", reg_rdata, 0);
    chk(settled == 1'b0, "R1", "settled in reset", settled, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pins_out == '0, "R1", "outputs after reset", pins_out, 0);
    @(negedge clk);
    chk(settled == 1'b0, "R1", "settled before third edge", settled, 0);
    @(negedge clk);
    chk(settled == 1'b1, "R1", "settled after third edge", settled, 1);
  endtask

  task automatic t_regfmt();
    wr(8'hFD);
    chk(reg_rdata == 8'h85, "R2", "reserved bits cleared", reg_rdata, 8'h85);
    wait_settled();
    wr(8'h7A);
    chk(reg_rdata == 8'h02, "R2", "enable low, code 2", reg_rdata, 8'h02);
    wait_settled();
    wr(8'h85);
    wait_settled();
  endtask

  task automatic t_illegal();
    bit low_seen = 0;
    wr(8'h86);
    chk(reg_rdata == 8'h85, "R3", "code 110 rejected", reg_rdata, 8'h85);
    for (int i = 0; i < 8; i++) begin
      if (!settled) low_seen = 1;
      @(negedge clk);
    end
    chk(!low_seen, "R3", "no restart on 110", low_seen, 0);
    wr(8'h07);
    chk(reg_rdata == 8'h05, "R3", "code 111 rejected, enable applied", reg_rdata, 8'h05);
    chk(settled == 1'b1, "R3", "settled kept on 111", settled, 1);
  endtask

  task automatic t_period(input int code);
    int d = period_of(code);
    int early = 0;
    wr(8'(code));
    for (int k = 0; k < 3 * d; k++) begin
      if (settled) early++;
      @(negedge clk);
    end
    chk(early == 0, "R5", $sformatf("settled low through reinit, code %0d", code), early, 0);
    chk(settled == 1'b1, "R4", $sformatf("settled at 3*%0d cycles, code %0d", d, code), settled, 1);
  endtask

  task automatic t_same_code();
    bit low_seen = 0;
    wr(reg_rdata);
    for (int i = 0; i < 6; i++) begin
      if (!settled) low_seen = 1;
      @(negedge clk);
    end
    chk(!low_seen, "R5", "same code keeps settled", low_seen, 0);
  endtask

  task automatic t_bypass();
    wr(8'h00);
    wait_settled();
    pins_in = 5'b00000;
    repeat (4) @(negedge clk);
    pins_in = 5'b10101;
    @(negedge clk);
    chk(pins_out == 5'b00000, "R6", "bypass after one edge", pins_out, 0);
    @(negedge clk);
    chk(pins_out == 5'b10101, "R6", "bypass after two edges", pins_out, 5'b10101);
    pins_in = 5'b01010;
    repeat (2) @(negedge clk);
    chk(pins_out == 5'b01010, "R6", "bypass second pattern", pins_out, 5'b01010);
    pins_in = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_step(input int code, input bit lvl);
    int d = period_of(code);
    int early = 0;
    pins_in[0] = lvl;
    for (int k = 0; k < 2 * d + 1; k++) begin
      @(negedge clk);
      if (pins_out[0] == lvl) early++;
    end
    chk(early == 0, "R7", $sformatf("no early change, code %0d lvl %0d", code, lvl), early, 0);
    repeat (d + 3) @(negedge clk);
    chk(pins_out[0] == lvl, "R7", $sformatf("steady level passes, code %0d", code), pins_out[0], lvl);
  endtask

  task automatic t_pulse(input int code, input int phase, input bit base);
    int d = period_of(code);
    int leaks = 0;
    pins_in = {NCH{base}};
    repeat (3 * d + 6) @(negedge clk);
    repeat (phase) @(negedge clk);
    pins_in[1] = !base;
    pins_in[0] = !base;
    for (int k = 0; k < 6 * d + 6; k++) begin
      if (k == 2 * d) pins_in[1] = base;
      @(negedge clk);
      if (pins_out[1] != base) leaks++;
    end
    chk(leaks == 0, "R8", $sformatf("pulse 2D blocked, code %0d phase %0d base %0d", code, phase, base),
        leaks, 0);
    chk(pins_out[0] == !base, "R10", $sformatf("neighbour unaffected, code %0d", code),
        pins_out[0], !base);
  endtask

  task automatic t_reinit();
    int moved = 0;
    wr(8'h81);
    wait_settled();
    pins_in = '1;
    repeat (20) @(negedge clk);
    chk(pins_out == '1, "R9", "high before reinit", pins_out, 5'b11111);
    @(negedge clk);
    reg_we = 1'b1;
    reg_wdata = 8'h83;
    pins_in = '0;
    @(negedge clk);
    reg_we = 1'b0;
    while (!settled) begin
      if (pins_out != '1) moved++;
      @(negedge clk);
    end
    chk(moved == 0, "R9", "held during reinit", moved, 0);
    repeat (3) @(negedge clk);
    chk(pins_out == '0, "R9", "follows once settled", pins_out, 0);
  endtask

  initial begin
    t_reset();
    t_regfmt();
    t_illegal();
    for (int c = 0; c < 6; c++) t_period(c);
    t_same_code();
    t_bypass();
    wr(8'h81);
    wait_settled();
    repeat (20) @(negedge clk);
    t_step(1, 1'b1);
    t_step(1, 1'b0);
    for (int p = 0; p < 4; p++) t_pulse(1, p, 1'b0);
    t_pulse(1, 1, 1'b1);
    wr(8'h80);
    wait_settled();
    t_pulse(0, 0, 1'b0);
    t_pulse(0, 0, 1'b1);
    wr(8'h82);
    wait_settled();
    t_pulse(2, 5, 1'b0);
    t_reinit();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule